// File: doc/BRIEF.md
# Microstep Register Datapath

This block is the register and arithmetic core of a microcoded processor. Each clock it performs one microstep. One register drives a shared B bus. A dedicated holding register supplies the ALU's A operand. The ALU result passes through a small shifter onto a C bus. The C bus is written at the clock edge into every register whose write-enable bit is set. The control word arrives fully decoded from an external sequencer: a B-source code, an ALU control field, a shifter control field and a C-bus write mask.

The N and Z flags come from the ALU output before the shifter. They are registered, so the sequencer can branch on them in the following cycle. Memory traffic is outside this block. It is represented only by two load hooks: one fills the memory data word register and one fills the 8-bit byte buffer. Register values are exported so that the memory side can use them.

Top module: `ucore_datapath`

## Requirements
- R1: After reset, all ten registers are zero and the N and Z flags are zero.
- R2: The B bus carries exactly one source per cycle, chosen by `b_sel`: 0 mdat, 1 iptr, 2 bbuf zero-extended, 4 stack, 5 frame, 6 konst, 7 head, 8 scratch. Codes 9 to 15 put zero on the bus. The holding register and madr are never B sources.
- R3: With `b_sel` = 3, the bus carries bbuf sign-extended from bit 7. With `b_sel` = 2, the upper bits are zero.
- R4: `alu_ctl[5:4]` selects the function: 00 is A AND B, 01 is A OR B, 10 is NOT B, 11 is A + B + carry-in.
- R5: In `alu_ctl`, bit 3 enables A and bit 2 enables B (a disabled operand reads as zero). Bit 1 inverts A after the enable. Bit 0 is the adder carry-in.
- R6: `shift_ctl` = 10 shifts the ALU result left by 8 bits, filling with zeros. `shift_ctl` = 01 shifts it right arithmetically by one bit. `shift_ctl` = 00 passes it unchanged.
- R7: `shift_ctl` = 11 is illegal. It raises `shift_err` in the same cycle and passes the ALU result unshifted.
- R8: At the clock edge the C bus is written into every register whose bit in `c_we` is set, and registers whose bit is clear keep their value. The bits are: 0 hold, 1 scratch, 2 head, 3 konst, 4 frame, 5 stack, 6 iptr, 7 mdat, 8 madr.
- R9: One cycle after the ALU produces a result, `n_flag` holds bit 31 of that result and `z_flag` shows whether it was zero. Both flags are taken before the shifter.
- R10: `mem_word_ld` loads mdat from `mem_word_in` and `mem_byte_ld` loads bbuf from `mem_byte_in`. If `c_we[7]` is set in the same cycle, the C bus wins for mdat.
- R11: The ALU A operand is always the holding register, which is written only from the C bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| b_sel | input | 4 | B-bus source code |
| alu_ctl | input | 6 | ALU function, enables, invert, carry-in |
| shift_ctl | input | 2 | Shifter control |
| c_we | input | 9 | C-bus write mask |
| mem_word_ld | input | 1 | Load mdat from memory |
| mem_word_in | input | 32 | Memory word |
| mem_byte_ld | input | 1 | Load bbuf from memory |
| mem_byte_in | input | 8 | Memory byte |
| hold_o | output | 32 | Holding register |
| scratch_o | output | 32 | Scratch register |
| head_o | output | 32 | Head register |
| konst_o | output | 32 | Constant-base register |
| frame_o | output | 32 | Frame register |
| stack_o | output | 32 | Stack register |
| iptr_o | output | 32 | Instruction pointer |
| mdat_o | output | 32 | Memory data word |
| madr_o | output | 32 | Memory address |
| bbuf_o | output | 8 | Byte buffer |
| n_flag | output | 1 | Registered negative flag |
| z_flag | output | 1 | Registered zero flag |
| shift_err | output | 1 | Illegal shifter code |

## Verification
The hardest cases to reach are the collision of a memory word load with a C-bus write to mdat, and the checks on the sign extension and the arithmetic right shift. Neither case can be built until the registers already hold negative or high-bit values. The stimulus therefore first loads values through the memory hooks. It then routes them through the ALU into chosen registers, which builds up a mix of negative and positive operands. The collision, the negative shifts and the illegal shifter code are applied only after that.

// File: rtl/ucore_datapath.sv
module ucore_datapath #(
  parameter int W  = 32,
  parameter int BW = 8,
  parameter int SL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    b_sel,
  input  logic [5:0]    alu_ctl,
  input  logic [1:0]    shift_ctl,
  input  logic [8:0]    c_we,
  input  logic          mem_word_ld,
  input  logic [W-1:0]  mem_word_in,
  input  logic          mem_byte_ld,
  input  logic [BW-1:0] mem_byte_in,
  output logic [W-1:0]  hold_o,
  output logic [W-1:0]  scratch_o,
  output logic [W-1:0]  head_o,
  output logic [W-1:0]  konst_o,
  output logic [W-1:0]  frame_o,
  output logic [W-1:0]  stack_o,
  output logic [W-1:0]  iptr_o,
  output logic [W-1:0]  mdat_o,
  output logic [W-1:0]  madr_o,
  output logic [BW-1:0] bbuf_o,
  output logic          n_flag,
  output logic          z_flag,
  output logic          shift_err
);
  localparam int NR   = 9;
  localparam int MDAT = 7;
  localparam int XW   = W - BW;

  logic [W-1:0]  rf [NR];
  logic [BW-1:0] bbuf_q;
  logic [W-1:0]  b_bus, a_op, b_op, alu_out, c_bus;
  logic          n_q, z_q;

  always_comb begin
    unique case (b_sel)
      4'd0:    b_bus = rf[7];
      4'd1:    b_bus = rf[6];
      4'd2:    b_bus = {{XW{1'b0}}, bbuf_q};
      4'd3:    b_bus = {{XW{bbuf_q[BW-1]}}, bbuf_q};
      4'd4:    b_bus = rf[5];
      4'd5:    b_bus = rf[4];
      4'd6:    b_bus = rf[3];
      4'd7:    b_bus = rf[2];
      4'd8:    b_bus = rf[1];
      default: b_bus = '0;
    endcase
  end

  assign a_op = (alu_ctl[3] ? rf[0] : '0) ^ {W{alu_ctl[1]}};
  assign b_op = alu_ctl[2] ? b_bus : '0;

  always_comb begin
    unique case (alu_ctl[5:4])
      2'b00: alu_out = a_op & b_op;
      2'b01: alu_out = a_op | b_op;
      2'b10: alu_out = ~b_op;
      default: alu_out = a_op + b_op + {{(W-1){1'b0}}, alu_ctl[0]};
    endcase
  end

  assign shift_err = &shift_ctl;

  always_comb begin
    unique case (shift_ctl)
      2'b10:   c_bus = alu_out << SL;
      2'b01:   c_bus = {alu_out[W-1], alu_out[W-1:1]};
      default: c_bus = alu_out;
    endcase
  end

  for (genvar i = 0; i < NR; i++) begin : g_reg
    if (i == MDAT) begin : g_mem
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)          rf[i] <= '0;
        else if (c_we[i])    rf[i] <= c_bus;
        else if (mem_word_ld) rf[i] <= mem_word_in;
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)       rf[i] <= '0;
        else if (c_we[i]) rf[i] <= c_bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           bbuf_q <= '0;
    else if (mem_byte_ld) bbuf_q <= mem_byte_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      n_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      n_q <= alu_out[W-1];
      z_q <= ~|alu_out;
    end

  assign hold_o    = rf[0];
  assign scratch_o = rf[1];
  assign head_o    = rf[2];
  assign konst_o   = rf[3];
  assign frame_o   = rf[4];
  assign stack_o   = rf[5];
  assign iptr_o    = rf[6];
  assign mdat_o    = rf[7];
  assign madr_o    = rf[8];
  assign bbuf_o    = bbuf_q;
  assign n_flag    = n_q;
  assign z_flag    = z_q;
endmodule

// File: rtl/ucore_datapath_chk.sv
module ucore_datapath_chk #(
  parameter int W  = 32,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    b_sel,
  input logic [1:0]    shift_ctl,
  input logic [8:0]    c_we,
  input logic [W-1:0]  b_bus,
  input logic [W-1:0]  alu_out,
  input logic [W-1:0]  c_bus,
  input logic [W-1:0]  hold_o,
  input logic [W-1:0]  head_o,
  input logic [BW-1:0] bbuf_o,
  input logic          n_flag,
  input logic          z_flag,
  input logic          shift_err
);
  // R2
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_sel > 4'd8) |-> (b_bus == '0));
  // R3
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_sel == 4'd3) |-> (b_bus[W-1:BW] == {(W-BW){bbuf_o[BW-1]}}));
  // R7
  bad_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_err |-> (c_bus == alu_out));
  // R8
  keep_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_we[2] |=> $stable(head_o));
  // R11
  hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_we[0] |=> (hold_o == $past(c_bus)));
  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (z_flag == ($past(alu_out) == '0)));
  // R9
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (n_flag == $past(alu_out[W-1])));
endmodule

bind ucore_datapath ucore_datapath_chk #(.W(W), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .b_sel(b_sel), .shift_ctl(shift_ctl), .c_we(c_we),
  .b_bus(b_bus), .alu_out(alu_out), .c_bus(c_bus), .hold_o(hold_o),
  .head_o(head_o), .bbuf_o(bbuf_o), .n_flag(n_flag), .z_flag(z_flag),
  .shift_err(shift_err)
);

// File: tb/ucore_datapath_tb.sv
module ucore_datapath_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  b_sel = 0;
  logic [5:0]  alu_ctl = 0;
  logic [1:0]  shift_ctl = 0;
  logic [8:0]  c_we = 0;
  logic        mem_word_ld = 0;
  logic [31:0] mem_word_in = 0;
  logic        mem_byte_ld = 0;
  logic [7:0]  mem_byte_in = 0;
  logic [31:0] hold_o, scratch_o, head_o, konst_o, frame_o, stack_o, iptr_o, mdat_o, madr_o;
  logic [7:0]  bbuf_o;
  logic        n_flag, z_flag, shift_err;

  ucore_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .b_sel(b_sel), .alu_ctl(alu_ctl), .shift_ctl(shift_ctl),
    .c_we(c_we), .mem_word_ld(mem_word_ld), .mem_word_in(mem_word_in),
    .mem_byte_ld(mem_byte_ld), .mem_byte_in(mem_byte_in), .hold_o(hold_o),
    .scratch_o(scratch_o), .head_o(head_o), .konst_o(konst_o), .frame_o(frame_o),
    .stack_o(stack_o), .iptr_o(iptr_o), .mdat_o(mdat_o), .madr_o(madr_o),
    .bbuf_o(bbuf_o), .n_flag(n_flag), .z_flag(z_flag), .shift_err(shift_err)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [9*32-1:0] regs;
    logic [7:0]      bb;
    logic            n;
    logic            z;
  } snap_t;

  snap_t  expq [$];
  string  tagq [$];
  logic [31:0] m [9];
  logic [7:0]  mb;
  int vectors = 0, errs = 0;
  bit done = 0;

  function automatic logic [9*32-1:0] pack_model();
    logic [9*32-1:0] v;
    for (int i = 0; i < 9; i++) v[i*32 +: 32] = m[i];
    return v;
  endfunction

  function automatic snap_t observe();
    snap_t s;
    s.regs = {madr_o, mdat_o, iptr_o, stack_o, frame_o, konst_o, head_o, scratch_o, hold_o};
    s.bb = bbuf_o;
    s.n = n_flag;
    s.z = z_flag;
    return s;
  endfunction

  task automatic step(input logic [3:0] bs, input logic [5:0] ac, input logic [1:0] sc,
                      input logic [8:0] we, input logic wl, input logic [31:0] wv,
                      input logic bl, input logic [7:0] bv, input string tag);
    logic [31:0] bus, a, b, r, c;
    snap_t e;
    @(negedge clk);
    b_sel = bs; alu_ctl = ac; shift_ctl = sc; c_we = we;
    mem_word_ld = wl; mem_word_in = wv; mem_byte_ld = bl; mem_byte_in = bv;
    case (bs)
      4'd0: bus = m[7];
      4'd1: bus = m[6];
      4'd2: bus = {24'h0, mb};
      4'd3: bus = {{24{mb[7]}}, mb};
      4'd4: bus = m[5];
      4'd5: bus = m[4];
      4'd6: bus = m[3];
      4'd7: bus = m[2];
      4'd8: bus = m[1];
      default: bus = 32'h0;
    endcase
    a = ac[3] ? m[0] : 32'h0;
    if (ac[1]) a = ~a;
    b = ac[2] ? bus : 32'h0;
    case (ac[5:4])
      2'b00: r = a & b;
      2'b01: r = a | b;
      2'b10: r = ~b;
      default: r = a + b + 32'(ac[0]);
    endcase
    case (sc)
      2'b10: c = {r[23:0], 8'h00};
      2'b01: c = {r[31], r[31:1]};
      default: c = r;
    endcase
    #1;
    vectors++;
    if (shift_err !== (sc == 2'b11)) begin
      errs++;
      $display("FAIL R7 shift_err actual %b expected %b", shift_err, sc == 2'b11);
    end
    if (wl) m[7] = wv;
    for (int i = 0; i < 9; i++) if (we[i]) m[i] = c;
    if (bl) mb = bv;
    e.regs = pack_model(); e.bb = mb; e.n = r[31]; e.z = (r == 32'h0);
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  always @(posedge clk) begin
    #5;
    if (expq.size() > 0) begin
      snap_t e, a;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      a = observe();
      vectors++;
      if (a !== e) begin
        errs++;
        $display("FAIL %s actual %h expected %h", t, a, e);
      end
    end
  end

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    snap_t a;
    for (int i = 0; i < 9; i++) m[i] = 0;
    mb = 0;
    #25;
    a = observe();
    vectors++;
    if (a !== '0) begin
      errs++;
      $display("FAIL R1 reset actual %h expected 0", a);
    end
    @(negedge clk); rst_n = 1;
    step(4'd15, 6'b000000, 2'b00, 9'h000, 1, 32'h8000_0001, 1, 8'h85, "R10 memory hooks");
    step(4'd0,  6'b110100, 2'b00, 9'h001, 0, 0, 0, 0, "R2 R11 mdat to hold");
    step(4'd2,  6'b110100, 2'b00, 9'h006, 0, 0, 0, 0, "R3 R8 zero-extend, two writes");
    step(4'd3,  6'b110100, 2'b00, 9'h008, 0, 0, 0, 0, "R3 sign-extend");
    step(4'd6,  6'b111100, 2'b00, 9'h010, 0, 0, 0, 0, "R4 add");
    step(4'd7,  6'b111101, 2'b00, 9'h020, 0, 0, 0, 0, "R5 carry-in");
    step(4'd5,  6'b001100, 2'b00, 9'h040, 0, 0, 0, 0, "R4 R9 and to zero");
    step(4'd4,  6'b011100, 2'b00, 9'h100, 0, 0, 0, 0, "R4 or");
    step(4'd1,  6'b100100, 2'b00, 9'h080, 1, 32'h1111_1111, 0, 0, "R10 C bus beats memory");
    step(4'd15, 6'b111011, 2'b00, 9'h002, 0, 0, 0, 0, "R5 negate A");
    step(4'd0,  6'b110100, 2'b10, 9'h004, 0, 0, 0, 0, "R6 R9 left shift");
    step(4'd6,  6'b110100, 2'b01, 9'h010, 0, 0, 0, 0, "R6 arithmetic right negative");
    step(4'd8,  6'b110100, 2'b01, 9'h020, 0, 0, 0, 0, "R6 arithmetic right positive");
    step(4'd7,  6'b110100, 2'b11, 9'h008, 0, 0, 0, 0, "R7 illegal shift");
    step(4'd12, 6'b110100, 2'b00, 9'h1FF, 0, 0, 0, 0, "R2 R8 unused code, all writes");
    step(4'd15, 6'b110010, 2'b00, 9'h004, 0, 0, 0, 0, "R5 disabled A inverted");
    step(4'd15, 6'b000000, 2'b00, 9'h000, 0, 0, 1, 8'h7F, "R10 byte load");
    step(4'd3,  6'b110100, 2'b00, 9'h002, 0, 0, 0, 0, "R3 sign-extend positive");
    step(4'd15, 6'b000000, 2'b00, 9'h000, 1, 32'hCAFE_F00D, 0, 0, "R10 word load alone");
    step(4'd0,  6'b111100, 2'b00, 9'h001, 0, 0, 0, 0, "R11 hold as A operand");
    @(negedge clk); c_we = 0; mem_word_ld = 0; mem_byte_ld = 0;
    @(negedge clk); @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule